// File: doc/BRIEF.md
# Serial Register Access Bridge

This block is a serial-peripheral target that lets an external host read and write 32-bit registers on an internal word-addressed bus. The host lowers chip select and clocks in a 24-bit address field, most significant byte first. The top bit of that field says whether the frame is a write or a read. A write frame carries four payload bytes straight after the address. A read frame first carries a programmable number of filler bytes. These give the internal access time to finish. The target then shifts out the four payload bytes.

Two words of the address space belong to the bridge itself and never reach the internal bus. The order word selects, at run time, the payload byte order and the bit order within each payload byte. The address field is always most significant bit first. The setup/status word holds the filler byte count, a fixed interface code, and a sticky flag. The flag records that a read had to start shifting before the internal bus had answered.

All serial inputs are oversampled in the system clock domain, so the host clock must be well below the system clock. Both bridge words return to their defaults on the synchronous reset.

Top module: `spi_reg_bridge`

## Requirements
- R1: A frame runs while `spi_cs_n` is low, using clock-polarity-0 and phase-0 timing: input is sampled on rising `spi_sclk` and output changes on falling `spi_sclk`. Raising `spi_cs_n` discards any partial frame, so a write cut off before its 32nd payload bit has no effect. `spi_miso` is 0 while no frame is active.
- R2: The 24-bit address field is sent MSB first. Field bit 23 is 1 for a write and 0 for a read. Field bits 22:0 are the word address, which appears unchanged on `bus_addr`.
- R3: After the 32nd payload bit of a write to any word other than 0 and 1, the bridge raises `bus_req` with `bus_we`=1 and the decoded word on `bus_wdata`. It holds `bus_req`, `bus_addr` and `bus_we` steady until `bus_rdy` is sampled high.
- R4: For a read of any word other than 0 and 1, `bus_req` rises with `bus_we`=0 once the address is complete. Then N filler bytes pass, where N is setup/status bits 3:0, and their input bits are ignored. Then 32 payload bits are driven, carrying the `bus_rdata` captured on `bus_rdy`.
- R5: Payload order is set by order-word bits 1:0. Bit 0 set means the word's byte 31:24 is sent first; clear means byte 7:0 is sent first. Bit 1 set means each byte is sent LSB first; clear means MSB first. Write payloads are decoded under the same order.
- R6: Writing word 0 takes the new order from bits 1:0 of the decoded word. Word 0 reads back as each of its four bytes equal to {b0,b1,0,0,0,0,b1,b0}, where b0 and b1 are order bits 0 and 1. When a write uses this same pattern, it selects that order whatever order is active when it is sent.
- R7: Word 1 (setup/status) holds the filler count in bits 3:0 and reads 2 in bits 31:24. All other bits read 0 except bit 16. A write to word 1 loads bits 3:0.
- R8: Bit 16 of word 1 is set when a read's first payload bit is due and the bus data has not arrived. In that case the read returns all zeros. The bit stays set until word 1 is written with bit 16 = 1; writing 0 there leaves it set.
- R9: The first payload bit is launched on the third rising `clk` edge after `spi_sclk` falls, because of a two-stage input synchronizer. A `bus_rdy` sampled on that same edge counts as on time. One edge later counts as late.
- R10: After reset the order bits are 00, the filler count is 0, the status bit is 0, and `bus_req` and `spi_miso` are 0.
- R11: Reads and writes of words 0 and 1 never raise `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing a transfer |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_req | output | 1 | Internal access request, held until ready |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 23 | Internal word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_rdy` |
| bus_rdy | input | 1 | One-cycle completion of the current access |

## Verification
The edge that launches the first read payload bit can coincide exactly with the cycle in which the internal bus returns its read data. The bench provokes this by releasing `bus_rdy` a fixed number of system clock edges after it drops the serial clock at the data boundary. It uses zero filler bytes and tries two offsets: one that lands on the launch edge itself and one that lands a single edge later. The first case must return the correct word and leave the status bit clear. The second must return zeros and set the status bit, which the bench then reads back through word 1.

// File: rtl/spi_bridge_pkg.sv
// Package: shared widths, the payload ordering type and the functions that
// map a 32-bit register word onto the serial bit stream and back.
// Assumes a 32-bit word made of 4 bytes.
package spi_bridge_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTES      = WORD_W / 8;
    localparam int FIELD_W    = 24;
    localparam int WADDR_W    = FIELD_W - 1;
    localparam int PAD_W      = 4;
    localparam int CNT_W      = 8;
    localparam logic [7:0] IFACE_CODE = 8'd2;

    // Payload ordering: bit 1 = LSB first inside a byte, bit 0 = high byte first.
    typedef struct packed {
        logic lsb_first;
        logic big_end;
    } order_t;

    // Word bit index carried by stream position k (k = 0 is sent first).
    function automatic int unsigned wire_pos(order_t o, int unsigned k);
        int unsigned slot;
        int unsigned j;
        int unsigned wbyte;
        int unsigned wbit;
        slot  = k / 8;
        j     = k % 8;
        wbyte = o.big_end ? (BYTES - 1 - slot) : slot;
        wbit  = o.lsb_first ? j : (7 - j);
        return wbyte * 8 + wbit;
    endfunction

    // Word to stream: stream MSB is shifted out first.
    function automatic logic [WORD_W-1:0] word_to_stream(logic [WORD_W-1:0] w, order_t o);
        logic [WORD_W-1:0] s;
        for (int unsigned k = 0; k < WORD_W; k++) begin
            s[WORD_W-1-k] = w[wire_pos(o, k)];
        end
        return s;
    endfunction

    // Stream to word: inverse of word_to_stream.
    function automatic logic [WORD_W-1:0] stream_to_word(logic [WORD_W-1:0] s, order_t o);
        logic [WORD_W-1:0] w;
        for (int unsigned k = 0; k < WORD_W; k++) begin
            w[wire_pos(o, k)] = s[WORD_W-1-k];
        end
        return w;
    endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2; reset loads RST_VAL into every stage.
module spi_bridge_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spi_bridge_front.sv
// Serial front end: synchronizes clock, select and data, and produces
// one-cycle strobes for rising and falling serial clock edges while selected.
// Assumes the serial clock is far slower than clk.
module spi_bridge_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);

    logic [2:0] synced;
    logic       sclk_s;
    logic       sclk_d;

    spi_bridge_sync #(
        .WIDTH(3),
        .STAGES(SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({sclk, cs_n, mosi}),
        .d_out(synced)
    );

    assign sclk_s = synced[2];
    assign cs_act = ~synced[1];
    assign mosi_s = synced[0];

    // Remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sck_rise = cs_act &  sclk_s & ~sclk_d;
    assign sck_fall = cs_act & ~sclk_s &  sclk_d;

endmodule

// File: rtl/spi_bridge_csr.sv
// Bridge-local registers: payload order word and setup/status word.
// A status set in the same cycle as a clear wins.
module spi_bridge_csr
    import spi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [1:0]        ctrl_bits,
    input  logic              wr_cfg,
    input  logic [PAD_W-1:0]  cfg_pad,
    input  logic              cfg_clr,
    input  logic              err_set,
    output order_t            order_q,
    output logic [PAD_W-1:0]  pad_q,
    output logic              err_q,
    output logic [WORD_W-1:0] ctrl_rd,
    output logic [WORD_W-1:0] cfg_rd
);

    localparam int LOW_GAP = 16 - PAD_W;

    // Update order, filler count and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= '0;
            pad_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (wr_ctrl) order_q <= order_t'(ctrl_bits);
            if (wr_cfg)  pad_q   <= cfg_pad;
            if (err_set)                err_q <= 1'b1;
            else if (wr_cfg && cfg_clr) err_q <= 1'b0;
        end
    end

    // Read-back images of both words.
    always_comb begin
        ctrl_rd = {BYTES{order_q.big_end, order_q.lsb_first, 4'b0000,
                         order_q.lsb_first, order_q.big_end}};
        cfg_rd  = {IFACE_CODE, 7'd0, err_q, {LOW_GAP{1'b0}}, pad_q};
    end

endmodule

// File: rtl/spi_reg_bridge.sv
// Top: serial frame engine and internal bus handshake. Decodes the address
// field, intercepts the two local words, issues bus accesses held until
// ready, and launches read payload after the programmed filler bytes.
// Assumes one outstanding bus access at a time.
module spi_reg_bridge
    import spi_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [WADDR_W-1:0] CTRL_WADDR = 23'd0,
    parameter logic [WADDR_W-1:0] CFG_WADDR  = 23'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic               bus_req,
    output logic               bus_we,
    output logic [WADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0]  bus_wdata,
    input  logic [WORD_W-1:0]  bus_rdata,
    input  logic               bus_rdy
);

    localparam logic [CNT_W-1:0] HDR_END = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0] WR_END  = CNT_W'(FIELD_W + WORD_W - 1);
    localparam logic [CNT_W-1:0] HDR_LEN = CNT_W'(FIELD_W);

    logic cs_act, sck_rise, sck_fall, mosi_s;

    logic [CNT_W-1:0]   bit_cnt;
    logic [WORD_W-2:0]  rx_sh;
    logic [WORD_W-1:0]  tx_sh;
    logic               hdr_done, is_wr, launched;
    logic [WADDR_W-1:0] waddr_q;
    logic [WORD_W-1:0]  rd_buf;
    logic               rd_have, rd_wait;

    order_t             order_q;
    logic [PAD_W-1:0]   pad_q;
    logic               err_q;
    logic [WORD_W-1:0]  ctrl_rd, cfg_rd;

    logic               hdr_last, hdr_wr, hdr_local, data_last, data_local;
    logic [WADDR_W-1:0] hdr_waddr;
    logic [WORD_W-1:0]  wr_word, launch_word;
    logic [CNT_W-1:0]   launch_cnt;
    logic               wr_ctrl, wr_cfg, wr_bus, do_launch, rdy_now, on_time, err_set;

    spi_bridge_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .cs_act  (cs_act),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .mosi_s  (mosi_s)
    );

    spi_bridge_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .ctrl_bits(wr_word[1:0]),
        .wr_cfg   (wr_cfg),
        .cfg_pad  (wr_word[PAD_W-1:0]),
        .cfg_clr  (wr_word[16]),
        .err_set  (err_set),
        .order_q  (order_q),
        .pad_q    (pad_q),
        .err_q    (err_q),
        .ctrl_rd  (ctrl_rd),
        .cfg_rd   (cfg_rd)
    );

    // Decode header completion, payload completion and the read launch point.
    always_comb begin
        hdr_last    = sck_rise && !hdr_done && (bit_cnt == HDR_END);
        hdr_wr      = rx_sh[WADDR_W-1];
        hdr_waddr   = {rx_sh[WADDR_W-2:0], mosi_s};
        hdr_local   = (hdr_waddr == CTRL_WADDR) || (hdr_waddr == CFG_WADDR);
        data_last   = sck_rise && hdr_done && is_wr && (bit_cnt == WR_END);
        data_local  = (waddr_q == CTRL_WADDR) || (waddr_q == CFG_WADDR);
        wr_word     = stream_to_word({rx_sh, mosi_s}, order_q);
        wr_ctrl     = data_last && (waddr_q == CTRL_WADDR);
        wr_cfg      = data_last && (waddr_q == CFG_WADDR);
        wr_bus      = data_last && !data_local;
        launch_cnt  = HDR_LEN + CNT_W'({pad_q, 3'b000});
        do_launch   = sck_fall && hdr_done && !is_wr && !launched && (bit_cnt == launch_cnt);
        rdy_now     = bus_req && bus_rdy && !bus_we && rd_wait;
        on_time     = rd_have || rdy_now;
        launch_word = rd_have ? rd_buf : bus_rdata;
        err_set     = do_launch && !on_time;
    end

    // Frame engine: bit counting, receive/transmit shifting, read buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            hdr_done <= 1'b0;
            is_wr    <= 1'b0;
            launched <= 1'b0;
            waddr_q  <= '0;
            rd_buf   <= '0;
            rd_have  <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            hdr_done <= 1'b0;
            is_wr    <= 1'b0;
            launched <= 1'b0;
            rd_have  <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sh <= {rx_sh[WORD_W-3:0], mosi_s};
                if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
            end
            if (hdr_last) begin
                hdr_done <= 1'b1;
                is_wr    <= hdr_wr;
                waddr_q  <= hdr_waddr;
                if (!hdr_wr && hdr_local) begin
                    rd_buf  <= (hdr_waddr == CTRL_WADDR) ? ctrl_rd : cfg_rd;
                    rd_have <= 1'b1;
                end
            end
            if (rdy_now) begin
                rd_buf  <= bus_rdata;
                rd_have <= 1'b1;
            end
            if (do_launch) begin
                launched <= 1'b1;
                tx_sh    <= on_time ? word_to_stream(launch_word, order_q) : '0;
            end else if (sck_fall && launched) begin
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Internal bus handshake: request held until ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rd_wait   <= 1'b0;
        end else begin
            if (bus_req && bus_rdy) begin
                bus_req <= 1'b0;
                rd_wait <= 1'b0;
            end
            if (!cs_act) rd_wait <= 1'b0;
            if (hdr_last && !hdr_wr && !hdr_local) begin
                bus_req  <= 1'b1;
                bus_we   <= 1'b0;
                bus_addr <= hdr_waddr;
                rd_wait  <= 1'b1;
            end
            if (wr_bus) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= waddr_q;
                bus_wdata <= wr_word;
            end
        end
    end

    assign spi_miso = tx_sh[WORD_W-1];

endmodule

// File: rtl/spi_reg_bridge_chk.sv
// Checker for spi_reg_bridge, attached by bind.
module spi_reg_bridge_chk
    import spi_bridge_pkg::*;
#(
    parameter logic [WADDR_W-1:0] CTRL_WADDR = 23'd0,
    parameter logic [WADDR_W-1:0] CFG_WADDR  = 23'd1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_rdy,
    input logic               bus_we,
    input logic [WADDR_W-1:0] bus_addr,
    input logic               err_q,
    input logic [PAD_W-1:0]   pad_q,
    input order_t             order_q,
    input logic               wr_cfg,
    input logic               wr_ctrl,
    input logic               cfg_clr,
    input logic               cs_act,
    input logic               spi_miso
);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> $stable(bus_addr) && $stable(bus_we));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !(wr_cfg && cfg_clr) |=> err_q);

    p_pad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(pad_q));

    p_order_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(order_q));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

    p_local_off_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (bus_addr != CTRL_WADDR) && (bus_addr != CFG_WADDR));

endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(
    .CTRL_WADDR(CTRL_WADDR),
    .CFG_WADDR (CFG_WADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_req (bus_req),
    .bus_rdy (bus_rdy),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .err_q   (err_q),
    .pad_q   (pad_q),
    .order_q (order_q),
    .wr_cfg  (wr_cfg),
    .wr_ctrl (wr_ctrl),
    .cfg_clr (wr_word[16]),
    .cs_act  (cs_act),
    .spi_miso(spi_miso)
);

// File: tb/sim_spi_reg_bridge.sv
`timescale 1ns/1ps
module sim_spi_reg_bridge;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic bus_req, bus_we, bus_rdy = 1'b0;
    logic [22:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;

    always #2.5 clk = ~clk;

    spi_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    int checks = 0;
    int fails = 0;
    int lat = 6;
    bit sync_mode = 0;
    int sync_k = 2;
    int req_rises = 0;
    logic req_prev = 1'b0;
    logic [1:0] cur_mode = 2'b00;
    event launch_ev;

    typedef struct { logic [31:0] val; string tag; } rd_item_t;
    typedef struct { logic [22:0] a; logic [31:0] d; string tag; } wr_item_t;
    rd_item_t exp_rd_q[$];
    rd_item_t got_rd_q[$];
    wr_item_t exp_wr_q[$];
    wr_item_t got_wr_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bus_model(input logic [22:0] a);
        return {a[7:0], 1'b1, a} ^ 32'h3C5A_9617;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // Stream bit 31 goes on the wire first.
    function automatic logic [31:0] to_stream(input logic [31:0] w, input logic [1:0] m);
        logic [31:0] s;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] wb;
            wb = m[0] ? w[8*(3-p) +: 8] : w[8*p +: 8];
            s[31-8*p -: 8] = m[1] ? rev8(wb) : wb;
        end
        return s;
    endfunction

    function automatic logic [31:0] from_stream(input logic [31:0] s, input logic [1:0] m);
        logic [31:0] w;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] wb;
            wb = m[1] ? rev8(s[31-8*p -: 8]) : s[31-8*p -: 8];
            if (m[0]) w[8*(3-p) +: 8] = wb;
            else      w[8*p +: 8] = wb;
        end
        return w;
    endfunction

    function automatic logic [31:0] ctrl_pat(input logic [1:0] m);
        return {4{m[0], m[1], 4'b0000, m[1], m[0]}};
    endfunction

    // Count request rising edges.
    always @(posedge clk) begin
        if (bus_req && !req_prev) req_rises <= req_rises + 1;
        req_prev <= bus_req;
    end

    // Internal bus target model.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (sync_mode) begin
                    @launch_ev;
                    repeat (sync_k) @(posedge clk);
                    @(negedge clk);
                end else begin
                    repeat (lat) @(negedge clk);
                end
                if (bus_we) got_wr_q.push_back('{bus_addr, bus_wdata, ""});
                bus_rdata = bus_model(bus_addr);
                bus_rdy = 1'b1;
                @(negedge clk);
                bus_rdy = 1'b0;
                bus_rdata = '0;
            end
        end
    end

    // Scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            while (got_rd_q.size() > 0 && exp_rd_q.size() > 0) begin
                rd_item_t e, g;
                e = exp_rd_q.pop_front();
                g = got_rd_q.pop_front();
                check(g.val === e.val, e.tag, g.val, e.val);
            end
            while (got_wr_q.size() > 0) begin
                wr_item_t g;
                g = got_wr_q.pop_front();
                if (exp_wr_q.size() == 0) begin
                    check(1'b0, "R1 unexpected bus write", {9'd0, g.a}, 32'h0);
                end else begin
                    wr_item_t e;
                    e = exp_wr_q.pop_front();
                    check(g.a === e.a, {e.tag, " addr"}, {9'd0, g.a}, {9'd0, e.a});
                    check(g.d === e.d, {e.tag, " data"}, g.d, e.d);
                end
            end
        end
    end

    task automatic spi_bit(input logic b, input bit fire, output logic r);
        @(negedge clk);
        sclk = 1'b0;
        mosi = b;
        if (fire) -> launch_ev;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        r = miso;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_end();
        @(negedge clk);
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic spi_write(input logic [22:0] wa, input logic [31:0] word, input int nbits);
        logic [23:0] hdr;
        logic [31:0] s;
        logic r;
        hdr = {1'b1, wa};
        s = to_stream(word, cur_mode);
        cs_begin();
        for (int i = 23; i >= 0; i--) spi_bit(hdr[i], 0, r);
        for (int i = 0; i < nbits; i++) spi_bit(s[31-i], 0, r);
        cs_end();
        repeat (lat + 8) @(negedge clk);
    endtask

    task automatic rd_expect(input logic [22:0] wa, input int pad, input bit trig,
                             input logic [31:0] exp, input string tag);
        logic [23:0] hdr;
        logic [31:0] s;
        logic r;
        exp_rd_q.push_back('{exp, tag});
        hdr = {1'b0, wa};
        cs_begin();
        for (int i = 23; i >= 0; i--) spi_bit(hdr[i], 0, r);
        for (int i = 0; i < pad * 8; i++) spi_bit(1'b1, 0, r);
        for (int i = 0; i < 32; i++) begin
            spi_bit(1'b0, trig && (i == 0), r);
            s[31-i] = r;
        end
        cs_end();
        got_rd_q.push_back('{from_stream(s, cur_mode), tag});
        repeat (lat + 8) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    // Main stimulus.
    initial begin
        int base;
        logic [1:0] modes [3];
        modes[0] = 2'b10; modes[1] = 2'b11; modes[2] = 2'b00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(miso === 1'b0, "R10 miso after reset", {31'd0, miso}, 32'd0);
        check(bus_req === 1'b0, "R10 bus_req after reset", {31'd0, bus_req}, 32'd0);

        base = req_rises;
        rd_expect(23'd1, 0, 0, 32'h0200_0000, "R7 R10 setup word default");
        rd_expect(23'd0, 0, 0, 32'h0000_0000, "R6 R10 order word default");
        spi_write(23'd0, ctrl_pat(2'b01), 32);
        cur_mode = 2'b01;
        rd_expect(23'd0, 0, 0, ctrl_pat(2'b01), "R6 order word 01");
        spi_write(23'd1, 32'h0000_0002, 32);
        rd_expect(23'd1, 2, 0, 32'h0200_0002, "R7 filler count 2");
        check(req_rises == base, "R11 local access on bus", req_rises, base);

        exp_wr_q.push_back('{23'h123456, 32'hDEAD_BEEF, "R3 R2 bus write"});
        spi_write(23'h123456, 32'hDEAD_BEEF, 32);
        lat = 40;
        rd_expect(23'h000ABC, 2, 0, bus_model(23'h000ABC), "R4 R5 read order 01");

        foreach (modes[i]) begin
            logic [22:0] a;
            logic [31:0] d;
            spi_write(23'd0, ctrl_pat(modes[i]), 32);
            cur_mode = modes[i];
            rd_expect(23'd0, 2, 0, ctrl_pat(modes[i]), "R6 order switch");
            a = 23'h040000 + 23'(i * 23'h1111);
            d = 32'h1234_5678 ^ {i[7:0], 24'h00F0F0};
            exp_wr_q.push_back('{a, d, "R5 write decode"});
            spi_write(a, d, 32);
            rd_expect(a, 2, 0, bus_model(a), "R5 read order");
        end
        rd_expect(23'h7FFFF0, 2, 0, bus_model(23'h7FFFF0), "R2 high word address");

        spi_write(23'd1, 32'h0000_0000, 32);
        lat = 30;
        rd_expect(23'h000100, 0, 0, 32'h0000_0000, "R8 late read zeros");
        rd_expect(23'd1, 0, 0, 32'h0201_0000, "R8 flag set");
        spi_write(23'd1, 32'h0000_0000, 32);
        rd_expect(23'd1, 0, 0, 32'h0201_0000, "R8 write 0 keeps flag");
        spi_write(23'd1, 32'h0001_0000, 32);
        rd_expect(23'd1, 0, 0, 32'h0200_0000, "R8 write 1 clears flag");

        sync_mode = 1;
        sync_k = 2;
        rd_expect(23'h000200, 0, 1, bus_model(23'h000200), "R9 ready on launch edge");
        sync_mode = 0;
        rd_expect(23'd1, 0, 0, 32'h0200_0000, "R9 no flag when on time");
        sync_mode = 1;
        sync_k = 3;
        rd_expect(23'h000204, 0, 1, 32'h0000_0000, "R9 ready one edge late");
        sync_mode = 0;
        rd_expect(23'd1, 0, 0, 32'h0201_0000, "R9 flag when late");
        spi_write(23'd1, 32'h0001_0000, 32);

        lat = 6;
        base = req_rises;
        spi_write(23'h000300, 32'hCAFE_F00D, 20);
        check(req_rises == base, "R1 cut write no request", req_rises, base);
        spi_write(23'd1, 32'h0000_0005, 20);
        rd_expect(23'd1, 0, 0, 32'h0200_0000, "R1 cut write keeps setup");

        spi_write(23'd0, ctrl_pat(2'b11), 32);
        cur_mode = 2'b11;
        spi_write(23'd1, 32'h0000_0003, 32);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_mode = 2'b00;
        repeat (4) @(negedge clk);
        rd_expect(23'd1, 0, 0, 32'h0200_0000, "R10 setup after reset");
        rd_expect(23'd0, 0, 0, 32'h0000_0000, "R10 order after reset");

        repeat (50) @(negedge clk);
        check(exp_rd_q.size() == 0, "R4 reads outstanding", exp_rd_q.size(), 0);
        check(exp_wr_q.size() == 0, "R3 writes outstanding", exp_wr_q.size(), 0);
        summary();
        $finish;
    end

endmodule